// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block is a purely combinational 32-bit binary adder. It takes two operands and a carry-in and returns a 32-bit sum with a carry-out. The word is split into ten ripple-carry groups of different widths. Each group has a bypass multiplexer. When every bit of the group propagates, the multiplexer passes the group's incoming carry straight to the next group. Otherwise it passes the carry that rippled through the group.

The groups are one bit wide at both ends of the word and six bits wide in the middle. A carry that starts near one end can reach the bypass chain after a few ripple steps. A carry that ends near the other end also needs only a few ripple steps after leaving the chain. This keeps the longest carry path short. The block has no clock or state, so it can sit inside any single-cycle datapath stage.

Top module: `vbsa_adder`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_i + b_i + cin_i`, with the operands read as unsigned numbers.
- R2: `cout_o` equals bit 32 of the unsigned sum `a_i + b_i + cin_i`.
- R3: When `a_i ^ b_i` is all ones, every bit of `sum_o` equals `~cin_i` and `cout_o` equals `cin_i`. The carry-in travels through every bypass.
- R4: The groups, from least to most significant, are 1,2,3,4,6,6,4,3,2,1 bits wide. Their lowest bits are 0,1,3,6,10,16,22,26,29,31. A group whose bits all propagate hands its carry-in unchanged to the next group.
- R5: A carry generated in the top bit of any group reaches the lowest bit of the next group. For a = b = bit t, where t is the top bit of a group, the sum is bit t+1; when t = 31 the sum is zero and `cout_o` = 1.
- R6: All ones plus a carry-in of one gives `sum_o` = 0 and `cout_o` = 1.
- R7: If the top bit of a group kills the carry (both operand bits 0), no carry leaves that group, whatever its carry-in.
- R8: The outputs depend only on the present inputs. The block holds no state, so results are the same whatever the order in which inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
Every result of this adder is due in the same cycle as its operands, since no register lies between the inputs and `sum_o`/`cout_o`. The bench changes the operands just after a rising clock edge and reads the outputs at the next falling edge. This leaves half a period for the bypass chain to settle and keeps sampling away from the edge where inputs move. Expected values come from a 33-bit behavioural sum computed in the bench. The directed vectors are placed on the group boundaries from R4, so a wrong group width or a miswired bypass shows up as a wrong bit.

// File: rtl/vbsa_pkg.sv
package vbsa_pkg;

    localparam int NUM_GRP   = 10;
    localparam int WORD_W    = 32;
    localparam int MAX_GRP_W = 6;

    typedef struct packed {
        logic [WORD_W-1:0] prop;
        logic [WORD_W-1:0] gen;
    } pg_vec_t;

    // Width of group idx, narrow at both ends and widest in the middle.
    function automatic int grp_size(input int idx);
        case (idx)
            0, 9:    return 1;
            1, 8:    return 2;
            2, 7:    return 3;
            3, 6:    return 4;
            default: return MAX_GRP_W;
        endcase
    endfunction

    // Lowest bit position of group idx.
    function automatic int grp_base(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += grp_size(k);
        return acc;
    endfunction

endpackage

// File: rtl/vbsa_pg.sv
module vbsa_pg
    import vbsa_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output pg_vec_t           pg_o
);
    always_comb begin
        pg_o.prop = a_i ^ b_i;
        pg_o.gen  = a_i & b_i;
    end
endmodule

// File: rtl/vbsa_group.sv
module vbsa_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] prop_i,
    input  logic [GW-1:0] gen_i,
    input  logic          cin_i,
    output logic [GW-1:0] cbit_o,
    output logic          cout_o
);
    localparam int CHAIN_W = GW + 1;

    logic [CHAIN_W-1:0] chain;
    logic               grp_prop;

    always_comb begin
        chain[0] = cin_i;
        for (int k = 0; k < GW; k++)
            chain[k+1] = gen_i[k] | (prop_i[k] & chain[k]);
    end

    assign cbit_o   = chain[GW-1:0];
    assign grp_prop = &prop_i;
    // Bypass multiplexer selected by the group propagate.
    assign cout_o   = grp_prop ? cin_i : chain[GW];

    always_comb begin
        // R4: a fully propagating group hands its carry-in straight on
        a_r4_skip_passes_cin: assert (!(&prop_i) || (cout_o == cin_i));
        // R7: a kill at the group's top bit stops any carry
        a_r7_top_kill: assert (prop_i[GW-1] || gen_i[GW-1] || !cout_o);
        // R5: a generate at the group's top bit always leaves the group
        a_r5_top_gen: assert (!gen_i[GW-1] || cout_o);
    end
endmodule

// File: rtl/vbsa_sum.sv
module vbsa_sum #(
    parameter int W = 32
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);
    assign sum_o = prop_i ^ carry_i;
endmodule

// File: rtl/vbsa_adder.sv
module vbsa_adder
    import vbsa_pkg::*;
#(
    parameter int WIDTH = vbsa_pkg::WORD_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int LAST_BIT = grp_base(NUM_GRP - 1) + grp_size(NUM_GRP - 1);

    pg_vec_t             pg;
    logic [WIDTH-1:0]    cvec;
    logic [NUM_GRP:0]    gcarry;

    vbsa_pg u_pg (
        .a_i  (a_i),
        .b_i  (b_i),
        .pg_o (pg)
    );

    assign gcarry[0] = cin_i;

    for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_grp
        localparam int BASE = grp_base(gi);
        localparam int SZ   = grp_size(gi);
        vbsa_group #(.GW(SZ)) u_grp (
            .prop_i (pg.prop[BASE +: SZ]),
            .gen_i  (pg.gen[BASE +: SZ]),
            .cin_i  (gcarry[gi]),
            .cbit_o (cvec[BASE +: SZ]),
            .cout_o (gcarry[gi+1])
        );
    end

    vbsa_sum #(.W(WIDTH)) u_sum (
        .prop_i  (pg.prop),
        .carry_i (cvec),
        .sum_o   (sum_o)
    );

    assign cout_o = gcarry[NUM_GRP];

    initial begin
        a_r4_layout_fills_word: assert (LAST_BIT == WIDTH && WIDTH == WORD_W);
    end

    always_comb begin
        // R1 and R2: ports agree with a behavioural add
        a_r1_r2_total: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
        // R3: full propagate sends the carry-in across the whole word
        a_r3_full_bypass: assert (!(&(a_i ^ b_i)) || ((sum_o == {WIDTH{~cin_i}}) && (cout_o == cin_i)));
    end
endmodule

// File: tb/sim_vbsa_adder.sv
module sim_vbsa_adder;

    localparam int W = 32;
    localparam int NV = 8;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         c;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'h0000_0001, 1'b0},
        '{32'h1234_5678, 32'h8765_4321, 1'b1},
        '{32'hFFFF_0000, 32'h0001_0000, 1'b0},
        '{32'hDEAD_BEEF, 32'h2152_4111, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 1'b0},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0},
        '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1},
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0}
    };

    localparam int BASES [11] = '{0, 1, 3, 6, 10, 16, 22, 26, 29, 31, 32};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a, b, sum;
    logic cin, cout;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vbsa_adder u0 (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv, input string req);
        logic [W:0] ref_v;
        @(posedge clk);
        a = av; b = bv; cin = cv;
        ref_v = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
        @(negedge clk);
        check(req, {cout, sum}, ref_v);
    endtask

    task automatic expect_val(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv,
                              input logic [W:0] exp, input string req);
        @(posedge clk);
        a = av; b = bv; cin = cv;
        @(negedge clk);
        check(req, {cout, sum}, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: idle state with zero operands
        check("R8 zero inputs", {cout, sum}, '0);

        // R1 R2: table of vectors
        for (int i = 0; i < NV; i++)
            apply(VECS[i].a, VECS[i].b, VECS[i].c, "R1/R2 table");

        // R6: all ones plus one
        expect_val('1, '0, 1'b1, {1'b1, {W{1'b0}}}, "R6 ones plus cin");
        expect_val('1, 32'h1, 1'b0, {1'b1, {W{1'b0}}}, "R6 ones plus b");

        // R3: full propagate, both carry-in values
        expect_val(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, {1'b1, {W{1'b0}}}, "R3 bypass cin=1");
        expect_val(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, {1'b0, {W{1'b1}}}, "R3 bypass cin=0");

        // R4 R5: generate at each group top bit lands on next group base
        for (int g = 0; g < 10; g++) begin
            logic [W:0] e;
            int t;
            t = BASES[g+1] - 1;
            e = '0;
            e[t+1] = 1'b1;
            expect_val(32'h1 << t, 32'h1 << t, 1'b0, e, "R5 group top generate");
        end

        // R4: one group fully propagating carries cin of that group onward
        for (int g = 0; g < 10; g++) begin
            logic [W-1:0] m;
            m = '0;
            for (int k = BASES[g]; k < BASES[g+1]; k++) m[k] = 1'b1;
            if (g == 0) apply(m, '0, 1'b1, "R4 group propagate");
            else        apply(m, 32'h1 << (BASES[g] - 1), 1'b0, "R4 group propagate");
            if (g > 0)  apply(m | (32'h1 << (BASES[g] - 1)), 32'h1 << (BASES[g] - 1), 1'b0, "R4 skip with gen below");
        end

        // R7: kill at each group top stops the carry
        for (int g = 0; g < 10; g++) begin
            logic [W-1:0] m;
            m = '1;
            m[BASES[g+1] - 1] = 1'b0;
            apply(m, '0, 1'b1, "R7 top kill");
        end

        // R1 R2 R8: random operands in arbitrary order
        for (int i = 0; i < 2000; i++)
            apply($urandom, $urandom, 1'($urandom), "R1/R2/R8 random");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule